// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

This block carries 32-bit words between a host and an embedded controller. It has two circular word buffers, one for each direction. The host pushes words into its outbound buffer through a write window. The controller drains that buffer through its own read window. Traffic in the other direction works the same way with the roles swapped.

Each side has one control word. That word packs:
- the fixed buffer depth,
- the free-running 8-bit write and read pointers of the buffer that side feeds,
- interrupt enable and interrupt status bits,
- a doorbell bit, a ready bit and a sticky error bit.

The host control word also carries a reset bit that empties both buffers.

Software finds the fill level by subtracting the read pointer from the write pointer modulo 256. A side rings the other by writing its control word with the doorbell bit set. This latches interrupt status on the far side, and an interrupt line rises there if that side has enabled interrupts. Both ports are plain single-cycle register buses with registered read data. Read data appears in the cycle after the request.

Top module: `cb_mailbox`

## Requirements
- R1: Each port has four word addresses: 0 for its own control word, 1 for its write window, 2 for its read window and 3 for a read-only view of the other side's control word. After reset, both control words read 0x20000000: the depth of 32 in bits 31:24 and every other field zero. Read data appears on the port in the cycle after the read request.
- R2: A control word holds the depth in bits 31:24, the write pointer in bits 23:16 and the read pointer in bits 15:8 of the buffer its side writes. The fill level (write pointer minus read pointer, modulo 256) never exceeds the depth. A write to a full window is dropped and sets the sticky error bit 5. Writing 1 to bit 5 clears it.
- R3: Each write to a write window stores the word at the write pointer and advances the pointer by one. Words come out in the order written, also across the 8-bit pointer wrap.
- R4: Each read of a read window returns the oldest stored word and advances the read pointer. A read of an empty window returns zero and leaves the pointer unchanged.
- R5: Interrupt status (bit 1) is cleared by writing 1 to it; writing 0 leaves it unchanged. When a clear and an incoming doorbell land in the same cycle, the status ends set.
- R6: Writing a control word with the doorbell bit 2 set latches interrupt status on the other side. Bit 2 always reads back as 0.
- R7: Each side's interrupt output is high exactly while that side's interrupt enable (bit 0) and interrupt status are both set.
- R8: While the host reset bit (bit 4 of the host word) is set, all four pointers are zero and window accesses from both sides are ignored; a read window then returns zero. The bit is also visible in bit 4 of the controller word. Writing the host word with reset cleared and the doorbell set rings the controller.
- R9: The ready bit 3 of each control word is written by its own side and is visible to the other side at address 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_en | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 2 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| h_irq | output | 1 | Host interrupt |
| c_en | input | 1 | Controller access strobe |
| c_we | input | 1 | Controller write (1) or read (0) |
| c_addr | input | 2 | Controller word address |
| c_wdata | input | 32 | Controller write data |
| c_rdata | output | 32 | Controller read data, registered |
| c_irq | output | 1 | Controller interrupt |

## Verification
The hardest case to reach is a collision on the host interrupt status: the host clears the bit in the same cycle that the controller rings the doorbell. Sequential bus tasks never produce that, so the bench drives both ports inside one shared cycle and then reads the status back. The other awkward case is the 8-bit pointer wrap with a 32-entry buffer. The bench reaches it by streaming several hundred push and pop pairs through each direction. Each popped word is compared with a value computed from its sequence number, and the final pointers are checked against the count modulo 256.

// File: rtl/cb_mailbox.sv
module cb_mailbox #(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_en,
  input  logic          h_we,
  input  logic [1:0]    h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq,
  input  logic          c_en,
  input  logic          c_we,
  input  logic [1:0]    c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          c_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] DEP8 = 8'(DEPTH);

  logic [7:0] dn_wp, dn_rp, up_wp, up_rp;
  logic [DW-1:0] dn_mem [DEPTH];
  logic [DW-1:0] up_mem [DEPTH];
  logic h_ie, h_is, h_rdy, h_rst, h_err;
  logic c_ie, c_is, c_rdy, c_err;

  wire [7:0] dn_fill  = dn_wp - dn_rp;
  wire [7:0] up_fill  = up_wp - up_rp;
  wire dn_full  = dn_fill == DEP8;
  wire up_full  = up_fill == DEP8;
  wire dn_empty = dn_fill == 8'd0;
  wire up_empty = up_fill == 8'd0;

  wire h_ctl_wr = h_en & h_we & (h_addr == 2'd0);
  wire c_ctl_wr = c_en & c_we & (c_addr == 2'd0);
  wire h_push   = h_en & h_we & (h_addr == 2'd1) & ~h_rst;
  wire c_push   = c_en & c_we & (c_addr == 2'd1) & ~h_rst;
  wire h_pop    = h_en & ~h_we & (h_addr == 2'd2) & ~h_rst;
  wire c_pop    = c_en & ~c_we & (c_addr == 2'd2) & ~h_rst;
  wire dn_push_ok = h_push & ~dn_full;
  wire up_push_ok = c_push & ~up_full;
  wire up_pop_ok  = h_pop & ~up_empty;
  wire dn_pop_ok  = c_pop & ~dn_empty;

  wire [DW-1:0] h_word = {DEP8, dn_wp, dn_rp, 2'b00, h_err, h_rst, h_rdy, 1'b0, h_is, h_ie};
  wire [DW-1:0] c_word = {DEP8, up_wp, up_rp, 2'b00, c_err, h_rst, c_rdy, 1'b0, c_is, c_ie};

  assign h_irq = h_ie & h_is;
  assign c_irq = c_ie & c_is;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_wp <= '0; dn_rp <= '0; up_wp <= '0; up_rp <= '0;
    end else if (h_rst) begin
      dn_wp <= '0; dn_rp <= '0; up_wp <= '0; up_rp <= '0;
    end else begin
      if (dn_push_ok) dn_wp <= dn_wp + 8'd1;
      if (dn_pop_ok)  dn_rp <= dn_rp + 8'd1;
      if (up_push_ok) up_wp <= up_wp + 8'd1;
      if (up_pop_ok)  up_rp <= up_rp + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (dn_push_ok) dn_mem[dn_wp[AW-1:0]] <= h_wdata;
    if (up_push_ok) up_mem[up_wp[AW-1:0]] <= c_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_ie <= 1'b0; h_is <= 1'b0; h_rdy <= 1'b0; h_rst <= 1'b0; h_err <= 1'b0;
    end else begin
      if (h_ctl_wr) begin
        h_ie  <= h_wdata[0];
        h_rdy <= h_wdata[3];
        h_rst <= h_wdata[4];
      end
      if (c_ctl_wr && c_wdata[2])      h_is <= 1'b1;
      else if (h_ctl_wr && h_wdata[1]) h_is <= 1'b0;
      if (h_push && dn_full)           h_err <= 1'b1;
      else if (h_ctl_wr && h_wdata[5]) h_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_ie <= 1'b0; c_is <= 1'b0; c_rdy <= 1'b0; c_err <= 1'b0;
    end else begin
      if (c_ctl_wr) begin
        c_ie  <= c_wdata[0];
        c_rdy <= c_wdata[3];
      end
      if (h_ctl_wr && h_wdata[2])      c_is <= 1'b1;
      else if (c_ctl_wr && c_wdata[1]) c_is <= 1'b0;
      if (c_push && up_full)           c_err <= 1'b1;
      else if (c_ctl_wr && c_wdata[5]) c_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) h_rdata <= '0;
    else if (h_en && !h_we) begin
      case (h_addr)
        2'd0: h_rdata <= h_word;
        2'd2: h_rdata <= up_pop_ok ? up_mem[up_rp[AW-1:0]] : '0;
        2'd3: h_rdata <= c_word;
        default: h_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) c_rdata <= '0;
    else if (c_en && !c_we) begin
      case (c_addr)
        2'd0: c_rdata <= c_word;
        2'd2: c_rdata <= dn_pop_ok ? dn_mem[dn_rp[AW-1:0]] : '0;
        2'd3: c_rdata <= h_word;
        default: c_rdata <= '0;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (8'(dn_wp - dn_rp) <= DEP8) && (8'(up_wp - up_rp) <= DEP8));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && h_we && h_addr == 2'd1 && !h_rst && dn_full) |=> ($stable(dn_wp) && h_err));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en && !h_we && h_addr == 2'd2 && up_empty) |=> (h_rdata == '0 && $stable(up_rp)));

  // R6
  bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && c_we && c_addr == 2'd0 && c_wdata[2]) |=> h_is);

  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rst |=> (dn_wp == 8'd0 && dn_rp == 8'd0 && up_wp == 8'd0 && up_rp == 8'd0));
endmodule

// File: tb/sim_cb_mailbox.sv
module sim_cb_mailbox;
  localparam int DEPTH = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_en = 0, h_we = 0, c_en = 0, c_we = 0;
  logic [1:0] h_addr = 0, c_addr = 0;
  logic [31:0] h_wdata = 0, c_wdata = 0, h_rdata, c_rdata;
  logic h_irq, c_irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  cb_mailbox #(.DEPTH(DEPTH), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .h_en(h_en), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .c_en(c_en),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_irq(c_irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] cw(input logic [7:0] wp, input logic [7:0] rp, input logic [7:0] lo);
    return {8'(DEPTH), wp, rp, lo};
  endfunction

  function automatic logic [31:0] dval(input int i);
    return 32'hA5000000 ^ (32'(i) * 32'h01010101);
  endfunction

  function automatic logic [31:0] uval(input int i);
    return 32'h5A000000 + 32'(i) * 32'h00010003;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); h_en = 1; h_we = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_en = 0; h_we = 0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); h_en = 1; h_we = 0; h_addr = a;
    @(negedge clk); h_en = 0; d = h_rdata;
  endtask

  task automatic cwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); c_en = 1; c_we = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_en = 0; c_we = 0;
  endtask

  task automatic crd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); c_en = 1; c_we = 0; c_addr = a;
    @(negedge clk); c_en = 0; d = c_rdata;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] dp, up;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    hrd(2'd0, d); check("R1 host word", d, cw(0, 0, 0));
    hrd(2'd3, d); check("R1 ctrl view", d, cw(0, 0, 0));
    crd(2'd0, d); check("R1 ctrl word", d, cw(0, 0, 0));
    check("R7 irqs idle", {30'd0, h_irq, c_irq}, 32'd0);

    // R2 R3 fill host buffer
    for (int i = 0; i < DEPTH; i++) begin
      hwr(2'd1, dval(i));
      hrd(2'd0, d); check("R2 fill step", d, cw(8'(i + 1), 0, 0));
    end
    hwr(2'd1, 32'hDEADBEEF);
    hrd(2'd0, d); check("R2 full drop err", d, cw(8'(DEPTH), 0, 8'h20));
    hwr(2'd0, 32'h20);
    hrd(2'd0, d); check("R2 err clear", d, cw(8'(DEPTH), 0, 0));

    // R4 drain in order, then empty
    for (int i = 0; i < DEPTH; i++) begin
      crd(2'd2, d); check("R4 pop order", d, dval(i));
    end
    crd(2'd2, d); check("R4 empty zero", d, 32'd0);
    crd(2'd3, d); check("R4 rp stays", d, cw(8'(DEPTH), 8'(DEPTH), 0));

    // R3 wrap sweep
    for (int k = 0; k < 300; k++) begin
      hwr(2'd1, dval(1000 + k));
      crd(2'd2, d); check("R3 wrap data", d, dval(1000 + k));
    end
    dp = 8'(DEPTH + 300);
    hrd(2'd0, d); check("R3 wrap ptrs", d, cw(dp, dp, 0));

    // R2 R3 R4 upward direction
    for (int i = 0; i < DEPTH; i++) cwr(2'd1, uval(i));
    cwr(2'd1, 32'h1);
    crd(2'd0, d); check("R2 up full err", d, cw(8'(DEPTH), 0, 8'h20));
    hrd(2'd3, d); check("R9 host sees ctrl word", d, cw(8'(DEPTH), 0, 8'h20));
    for (int i = 0; i < DEPTH; i++) begin
      hrd(2'd2, d); check("R4 up pop order", d, uval(i));
    end
    hrd(2'd2, d); check("R4 up empty zero", d, 32'd0);
    cwr(2'd0, 32'h20);
    for (int k = 0; k < 260; k++) begin
      cwr(2'd1, uval(500 + k));
      hrd(2'd2, d); check("R3 up wrap data", d, uval(500 + k));
    end
    up = 8'(DEPTH + 260);
    crd(2'd0, d); check("R3 up wrap ptrs", d, cw(up, up, 0));

    // R6 R7 R5 doorbells
    hwr(2'd0, 32'h04);
    crd(2'd0, d); check("R6 ctrl status set", d, cw(up, up, 8'h02));
    hrd(2'd0, d); check("R6 bell reads zero", d, cw(dp, dp, 0));
    check("R7 ctrl irq masked", {31'd0, c_irq}, 32'd0);
    cwr(2'd0, 32'h01);
    crd(2'd0, d); check("R5 write zero keeps", d, cw(up, up, 8'h03));
    check("R7 ctrl irq on", {31'd0, c_irq}, 32'd1);
    cwr(2'd0, 32'h03);
    crd(2'd0, d); check("R5 w1c clears", d, cw(up, up, 8'h01));
    check("R7 ctrl irq off", {31'd0, c_irq}, 32'd0);
    cwr(2'd0, 32'h04);
    hrd(2'd0, d); check("R6 host status set", d, cw(dp, dp, 8'h02));
    check("R7 host irq masked", {31'd0, h_irq}, 32'd0);
    hwr(2'd0, 32'h01);
    check("R7 host irq on", {31'd0, h_irq}, 32'd1);
    hwr(2'd0, 32'h03);
    check("R7 host irq off", {31'd0, h_irq}, 32'd0);

    // R5 collision: clear and doorbell in the same cycle
    @(negedge clk);
    h_en = 1; h_we = 1; h_addr = 2'd0; h_wdata = 32'h03;
    c_en = 1; c_we = 1; c_addr = 2'd0; c_wdata = 32'h04;
    @(negedge clk);
    h_en = 0; h_we = 0; c_en = 0; c_we = 0;
    hrd(2'd0, d); check("R5 set wins", d, cw(dp, dp, 8'h03));
    check("R7 host irq after collision", {31'd0, h_irq}, 32'd1);
    hwr(2'd0, 32'h02);
    hrd(2'd0, d); check("R5 cleared", d, cw(dp, dp, 0));

    // R9 ready bits
    hwr(2'd0, 32'h08);
    crd(2'd3, d); check("R9 host ready seen", d, cw(dp, dp, 8'h08));
    cwr(2'd0, 32'h08);
    hrd(2'd3, d); check("R9 ctrl ready seen", d, cw(up, up, 8'h08));

    // R8 buffer reset bit
    for (int i = 0; i < 3; i++) hwr(2'd1, dval(i));
    for (int i = 0; i < 2; i++) cwr(2'd1, uval(i));
    hwr(2'd0, 32'h18);
    hrd(2'd0, d); check("R8 host ptrs zero", d, cw(0, 0, 8'h18));
    hrd(2'd3, d); check("R8 ctrl ptrs zero", d, cw(0, 0, 8'h18));
    hwr(2'd1, 32'h12345678);
    hrd(2'd0, d); check("R8 push ignored", d, cw(0, 0, 8'h18));
    crd(2'd2, d); check("R8 pop zero", d, 32'd0);
    hwr(2'd0, 32'h0C);
    crd(2'd0, d); check("R8 release rings", d, cw(0, 0, 8'h0A));
    hwr(2'd1, 32'hCAFEF00D);
    crd(2'd2, d); check("R8 resumes", d, 32'hCAFEF00D);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule